// File: doc/BRIEF.md
# Serial-to-Parallel LED Shift Controller

This peripheral feeds a chain of external 8-bit shift registers, typically driving status LEDs, from a 24-bit CPU data word held in a small register bank. On each update it captures a frame, clocks it out on a serial data pin with its own serial clock, and closes the frame with a one-cycle store strobe. The external registers move the shifted bits to their parallel outputs on that strobe.

An update comes from one of two places. Software can request a single shift-out. A rate timer, derived from the bus clock, can also fire updates at 2, 4, 8 or 10 Hz. The lowest eight output bits can be taken over, bit by bit, by hardware status inputs: two line-status bits and two groups of three port-status bits. Each of those output bits then follows its hardware input and no longer follows the CPU data. Any output bit that is driven by hardware needs periodic updates to stay current, so software turns on the rate timer in that case.

Software reaches the block over a plain 32-bit register bus. Reads are combinational from the address. A write takes effect on the clock edge where `busWrite` is high.

Top module: `serial_led_driver`

## Requirements
- R1: After reset, the register at offset 0x00 reads 0x8000_0000. The registers at 0x04, 0x08, 0x0C and 0x10 read 0. `serClk` and `serStore` are low.
- R2: The register at 0x04 and the register at 0x0C read back exactly what was written. The register at 0x08 keeps only bits [23:0] of a write, and its upper bits read 0. Writes to 0x10 are ignored. Bit 0 of 0x10 reads 1 while a frame is being shifted or stored, and 0 otherwise.
- R3: The group field is bits [2:0] of 0x04. The frame length is 8, 16 or 24 bits, set by the highest set bit of that field. When the field is 0, no frame is sent and any request stays pending.
- R4: Bit 26 of 0x00 selects the shift-clock edge. When it is 0, `serClk` idles low and data is valid for the rising edge. When it is 1, `serClk` idles high and data is valid for the falling edge.
- R5: Each ownership bit hands one output bit to a hardware input, and the hardware value is taken when the frame starts. Bits [25:24] of 0x00 hand output bits 1:0 to `dslIn[1:0]`. Bits [29:27] of 0x00 hand output bits 4:2 to `phy1In[2:0]`. Bits [17:15] of 0x04 hand output bits 7:5 to `phy2In[2:0]`. Every other bit comes from the register at 0x08.
- R6: Writing 1 to bit 31 of 0x00 requests exactly one frame. Writing 0 to that bit requests nothing. The bit reads 1 from the request until the frame begins.
- R7: Bits go out most significant first, so bit 0 is the last bit shifted. Each bit takes two bus clocks and gets one active clock edge. `serStore` goes high for exactly one cycle after the last bit.
- R8: When bit 31 of 0x04 is 1, a frame starts every CLK_HZ/f bus clocks. The rate f is set by bits [24:23] of 0x04: 00 gives 2 Hz, 01 gives 4 Hz, 10 gives 8 Hz and 11 gives 10 Hz. A timer tick that arrives while a frame is in progress is dropped.
- R9: A software request made during a frame is held. The next frame starts in the cycle after the store strobe, so two back-to-back frames of length L are spaced 2L+2 clocks apart. A software request and a timer tick in the same idle cycle produce a single frame and clear the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte address of the register |
| busWrite | input | 1 | Write enable |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational from busAddr) |
| dslIn | input | 2 | Line-status inputs for output bits 1:0 |
| phy1In | input | 3 | First port-status group, output bits 4:2 |
| phy2In | input | 3 | Second port-status group, output bits 7:5 |
| serData | output | 1 | Serial data to the cascade |
| serClk | output | 1 | Serial shift clock |
| serStore | output | 1 | Store strobe that latches the cascade outputs |

## Verification
A software update and a rate-timer tick can land in the same idle cycle. The bench predicts the tick cycle from the spacing of earlier store strobes, then times a bus write so that the request becomes pending in exactly that cycle. It judges the outcome in three ways. Exactly one frame must start on the tick. The update bit must read back 0 afterwards. No second frame may follow before the next tick. A related overlap, a software request held while a frame is still shifting, is checked by measuring the 2L+2 clock spacing between the two store strobes.

// File: rtl/sld_pkg.sv
`timescale 1ns/1ps
package sld_pkg;
  // Strobes and levels from the sequencer to the shift datapath
  typedef struct packed {
    logic load;      // capture a new frame this cycle
    logic advance;   // move to the next bit at this edge
    logic clkPhase;  // 1 while the shift clock sits at its active level
    logic store;     // store strobe cycle
    logic edgeFall;  // 1: falling edge is the capture edge
  } shiftCmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_STORE} seqState_t;
endpackage

// File: rtl/sld_shift_path.sv
`timescale 1ns/1ps
module sld_shift_path
  import sld_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int OWN_W  = 8,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftCmd_t         cmd,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [DATA_W-1:0] cpuData,
  input  logic [OWN_W-1:0]  ownMask,
  input  logic [OWN_W-1:0]  hwIn,
  output logic              serData,
  output logic              serClk,
  output logic              serStore
);
  logic [DATA_W-1:0] mixed;
  logic [DATA_W-1:0] shiftQ;

  // Per-bit source choice: hardware inputs may own the low bits
  for (genvar i = 0; i < DATA_W; i++) begin : g_mix
    if (i < OWN_W) begin : g_own
      assign mixed[i] = ownMask[i] ? hwIn[i] : cpuData[i];
    end else begin : g_cpu
      assign mixed[i] = cpuData[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (cmd.load) begin
      // Left-align so the top enabled bit sits at the MSB
      shiftQ <= mixed << (DATA_W - int'(frameLen));
    end else if (cmd.advance) begin
      shiftQ <= shiftQ << 1;
    end
  end

  assign serData  = shiftQ[DATA_W-1];
  assign serClk   = cmd.edgeFall ^ cmd.clkPhase;
  assign serStore = cmd.store;

  // Checker state: active edges seen in the current frame
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] edgeCnt;
  logic             phasePrev;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenQ      <= '0;
      edgeCnt   <= '0;
      phasePrev <= 1'b0;
    end else begin
      phasePrev <= cmd.clkPhase;
      if (cmd.load) begin
        lenQ    <= frameLen;
        edgeCnt <= '0;
      end else if (cmd.clkPhase && !phasePrev) begin
        edgeCnt <= edgeCnt + 1'b1;
      end
    end
  end

  // R7: one active clock edge per bit of the frame before the strobe
  a_r7_edge_count: assert property (@(posedge clk) disable iff (!rstN)
    cmd.store |-> edgeCnt == lenQ);
  // R4: data does not move across the active edge
  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clkPhase |-> $stable(serData));
endmodule

// File: rtl/sld_ctrl.sv
`timescale 1ns/1ps
module sld_ctrl
  import sld_pkg::*;
#(
  parameter int GROUPS  = 3,
  parameter int GROUP_W = 8,
  parameter int OWN_W   = 8,
  parameter int ADDR_W  = 5,
  parameter int CLK_HZ  = 125_000_000,
  localparam int DATA_W = GROUPS * GROUP_W,
  localparam int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output shiftCmd_t         cmd,
  output logic [LEN_W-1:0]  frameLen,
  output logic [DATA_W-1:0] cpuData,
  output logic [OWN_W-1:0]  ownMask
);
  localparam int P2    = (CLK_HZ / 2  > 0) ? CLK_HZ / 2  : 1;
  localparam int P4    = (CLK_HZ / 4  > 0) ? CLK_HZ / 4  : 1;
  localparam int P8    = (CLK_HZ / 8  > 0) ? CLK_HZ / 8  : 1;
  localparam int P10   = (CLK_HZ / 10 > 0) ? CLK_HZ / 10 : 1;
  localparam int CNT_W = $clog2(P2 + 1);
  localparam logic [ADDR_W-1:0] A_CFG0 = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_CFG1 = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_DAT0 = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_DAT1 = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h10);

  logic [30:0]       cfg0Q;
  logic              swPend;
  logic [31:0]       cfg1Q;
  logic [DATA_W-1:0] dat0Q;
  logic [31:0]       dat1Q;
  seqState_t         state;
  logic              phaseQ;
  logic [LEN_W-1:0]  bitCnt;
  logic [CNT_W-1:0]  tmrQ, period;
  logic              autoEn, tick, start, busy, wrCfg0;

  assign wrCfg0 = busWrite && busAddr == A_CFG0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg0Q <= '0;
      cfg1Q <= '0;
      dat0Q <= '0;
      dat1Q <= '0;
    end else if (busWrite) begin
      if (busAddr == A_CFG0) cfg0Q <= busWdata[30:0];
      if (busAddr == A_CFG1) cfg1Q <= busWdata;
      if (busAddr == A_DAT0) dat0Q <= busWdata[DATA_W-1:0];
      if (busAddr == A_DAT1) dat1Q <= busWdata;
    end
  end

  // Frame length from the highest enabled group
  always_comb begin
    frameLen = '0;
    for (int g = 0; g < GROUPS; g++)
      if (cfg1Q[g]) frameLen = LEN_W'((g + 1) * GROUP_W);
  end

  // Rate timer clocked from the bus clock
  assign autoEn = cfg1Q[31];
  always_comb begin
    case (cfg1Q[24:23])
      2'b00:   period = CNT_W'(P2);
      2'b01:   period = CNT_W'(P4);
      2'b10:   period = CNT_W'(P8);
      default: period = CNT_W'(P10);
    endcase
  end
  assign tick = autoEn && (tmrQ >= period - 1'b1);
  always_ff @(posedge clk) begin
    if (!rstN || !autoEn || tick) tmrQ <= '0;
    else                          tmrQ <= tmrQ + 1'b1;
  end

  assign start = (state == ST_IDLE) && (swPend || tick) && (frameLen != '0);
  assign busy  = (state != ST_IDLE);

  // A new request written in the start cycle wins over the clear
  always_ff @(posedge clk) begin
    if (!rstN)                        swPend <= 1'b1;
    else if (wrCfg0 && busWdata[31])  swPend <= 1'b1;
    else if (start)                   swPend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phaseQ <= 1'b0;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_SHIFT;
          phaseQ <= 1'b0;
          bitCnt <= frameLen - 1'b1;
        end
        ST_SHIFT: begin
          phaseQ <= ~phaseQ;
          if (phaseQ) begin
            if (bitCnt == '0) state <= ST_STORE;
            else              bitCnt <= bitCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd.load     = start;
  assign cmd.advance  = (state == ST_SHIFT) && phaseQ;
  assign cmd.clkPhase = (state == ST_SHIFT) && phaseQ;
  assign cmd.store    = (state == ST_STORE);
  assign cmd.edgeFall = cfg0Q[26];
  assign cpuData      = dat0Q;
  assign ownMask      = {cfg1Q[17:15], cfg0Q[29:27], cfg0Q[25:24]};

  always_comb begin
    case (busAddr)
      A_CFG0:  busRdata = {swPend, cfg0Q};
      A_CFG1:  busRdata = cfg1Q;
      A_DAT0:  busRdata = 32'(dat0Q);
      A_DAT1:  busRdata = dat1Q;
      A_STAT:  busRdata = {31'b0, busy};
      default: busRdata = '0;
    endcase
  end

  // R7: the store strobe lasts a single cycle
  a_r7_store_single: assert property (@(posedge clk) disable iff (!rstN)
    cmd.store |=> !cmd.store);
  // R9: a request made during a frame is never lost
  a_r9_pend_held: assert property (@(posedge clk) disable iff (!rstN)
    (swPend && busy) |=> swPend);
  // R3: no frame begins while no group is enabled
  a_r3_no_empty: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(frameLen) != '0);
endmodule

// File: rtl/serial_led_driver.sv
`timescale 1ns/1ps
module serial_led_driver #(
  parameter int GROUPS  = 3,
  parameter int GROUP_W = 8,
  parameter int ADDR_W  = 5,
  parameter int CLK_HZ  = 125_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [1:0]        dslIn,
  input  logic [2:0]        phy1In,
  input  logic [2:0]        phy2In,
  output logic              serData,
  output logic              serClk,
  output logic              serStore
);
  localparam int DATA_W = GROUPS * GROUP_W;
  localparam int LEN_W  = $clog2(DATA_W + 1);
  localparam int OWN_W  = 8;

  sld_pkg::shiftCmd_t cmd;
  logic [LEN_W-1:0]   frameLen;
  logic [DATA_W-1:0]  cpuData;
  logic [OWN_W-1:0]   ownMask;

  sld_ctrl #(.GROUPS(GROUPS), .GROUP_W(GROUP_W), .OWN_W(OWN_W),
             .ADDR_W(ADDR_W), .CLK_HZ(CLK_HZ)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .cmd(cmd),
    .frameLen(frameLen), .cpuData(cpuData), .ownMask(ownMask));

  sld_shift_path #(.DATA_W(DATA_W), .OWN_W(OWN_W), .LEN_W(LEN_W)) u_path (
    .clk(clk), .rstN(rstN), .cmd(cmd), .frameLen(frameLen),
    .cpuData(cpuData), .ownMask(ownMask),
    .hwIn({phy2In, phy1In, dslIn}),
    .serData(serData), .serClk(serClk), .serStore(serStore));
endmodule

// File: tb/serial_led_driver_bench.sv
`timescale 1ns/1ps
module serial_led_driver_bench;
  localparam int CLK_HZ = 4000;

  logic        clk = 0, rstN = 0, busWrite = 0;
  logic [4:0]  busAddr = 0;
  logic [31:0] busWdata = 0, busRdata;
  logic [1:0]  dslIn = 0;
  logic [2:0]  phy1In = 0, phy2In = 0;
  logic        serData, serClk, serStore;

  serial_led_driver #(.CLK_HZ(CLK_HZ)) u_serial_led_driver (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .dslIn(dslIn),
    .phy1In(phy1In), .phy2In(phy2In), .serData(serData),
    .serClk(serClk), .serStore(serStore));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // Model of the external cascade, sampled on the falling bus edge
  logic [23:0] casReg = 0, lastFrame = 0;
  int bitsSeen = 0, lastBits = 0, frames = 0, storeCyc = 0, prevStoreCyc = 0;
  bit edgeMode = 0;
  logic prevClk = 0;
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if ((!edgeMode && !prevClk && serClk) || (edgeMode && prevClk && !serClk)) begin
        casReg = {casReg[22:0], serData};
        bitsSeen++;
      end
      if (serStore) begin
        lastFrame = casReg; lastBits = bitsSeen; bitsSeen = 0;
        prevStoreCyc = storeCyc; storeCyc = cyc; frames++;
      end
    end
    prevClk = serClk;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWrite = 1;
    @(negedge clk); busWrite = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    busAddr = a; #1; d = busRdata;
  endtask

  task automatic waitFrame(int n0);
    for (int k = 0; k < 3000 && frames <= n0; k++) @(negedge clk);
    #1;
  endtask

  function automatic int lenOf(logic [2:0] g);
    return g[2] ? 24 : g[1] ? 16 : g[0] ? 8 : 0;
  endfunction

  function automatic logic [23:0] expFrame(logic [23:0] d, logic [7:0] own,
                                           logic [7:0] hw, int len);
    logic [23:0] m = d;
    for (int i = 0; i < 8; i++) if (own[i]) m[i] = hw[i];
    return m & ((24'h1 << len) - 1);
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int n0, t;
    void'($urandom(32'h1ed5));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    rd(5'h00, r); chk("R1 cfg0", r, 32'h8000_0000);
    rd(5'h04, r); chk("R1 cfg1", r, 0);
    rd(5'h08, r); chk("R1 dat0", r, 0);
    rd(5'h0C, r); chk("R1 dat1", r, 0);
    rd(5'h10, r); chk("R1 stat", r, 0);
    chk("R1 pins", {30'b0, serClk, serStore}, 0);
    // R2 register access
    wr(5'h0C, 32'hDEAD_BEEF); rd(5'h0C, r); chk("R2 dat1", r, 32'hDEAD_BEEF);
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, r); chk("R2 dat0 width", r, 32'h00FF_FFFF);
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, r); chk("R2 stat write ignored", r, 0);
    // R3 pending reset request waits for a group, then 8-bit frame
    wr(5'h08, 32'h0000_00A5);
    repeat (60) @(negedge clk);
    chk("R3 no frame with zero groups", frames, 0);
    n0 = frames; wr(5'h04, 32'h1); waitFrame(n0);
    chk("R3 len8 bits", lastBits, 8);
    chk("R7 len8 value", 32'(lastFrame[7:0]), 32'hA5);
    rd(5'h00, r); chk("R6 request cleared", r[31], 0);
    // R3 zero groups keeps a new request pending
    wr(5'h04, 0); wr(5'h08, 32'h00_C3_5A);
    wr(5'h00, 32'h8000_0000); n0 = frames;
    repeat (60) @(negedge clk);
    chk("R3 held no frame", frames, n0);
    rd(5'h00, r); chk("R3 still pending", r[31], 1);
    wr(5'h04, 32'h2); waitFrame(n0);
    chk("R3 len16 value", 32'(lastFrame[15:0]), 32'hC35A);
    chk("R3 len16 bits", lastBits, 16);
    // R6 writing 0 to the update bit does nothing
    n0 = frames; wr(5'h00, 32'h0);
    repeat (60) @(negedge clk);
    chk("R6 zero write no frame", frames, n0);
    // Random frames: R4 edge, R5 override, R7 order, R2 busy
    for (int it = 0; it < 16; it++) begin
      logic [23:0] d; logic [2:0] g, p1, p2; logic [1:0] ds; logic e; logic [7:0] hw;
      d = 24'($urandom); g = 3'($urandom_range(1, 7)); e = 1'($urandom);
      p1 = 3'($urandom); p2 = 3'($urandom); ds = 2'($urandom); hw = 8'($urandom);
      edgeMode = e; {phy2In, phy1In, dslIn} = hw;
      wr(5'h08, 32'(d));
      wr(5'h04, (32'(p2) << 15) | 32'(g));
      n0 = frames;
      wr(5'h00, 32'h8000_0000 | (32'(p1) << 27) | (32'(e) << 26) | (32'(ds) << 24));
      @(negedge clk); rd(5'h10, r); chk("R2 busy", r, 1);
      waitFrame(n0);
      chk("R7 bit count", lastBits, lenOf(g));
      chk("R5 frame value", 32'(lastFrame & ((24'h1 << lenOf(g)) - 1)),
          32'(expFrame(d, {p2, p1, ds}, hw, lenOf(g))));
      repeat (2) @(negedge clk);
      chk("R4 idle clock level", serClk, e);
    end
    // R9 request during a shift
    edgeMode = 0; {phy2In, phy1In, dslIn} = 0;
    wr(5'h04, 32'h4); wr(5'h08, 32'h12_3456); n0 = frames;
    wr(5'h00, 32'h8000_0000);
    repeat (6) @(negedge clk);
    wr(5'h08, 32'hAB_CDEF); wr(5'h00, 32'h8000_0000);
    rd(5'h00, r); chk("R9 pending during shift", r[31], 1);
    waitFrame(n0); chk("R9 first frame", 32'(lastFrame), 32'h12_3456);
    waitFrame(n0 + 1); chk("R9 second frame", 32'(lastFrame), 32'hAB_CDEF);
    chk("R9 spacing", storeCyc - prevStoreCyc, 50);
    // R8 automatic rates: code 11 -> 400 clocks, code 10 -> 500 clocks
    wr(5'h04, 32'h8000_0001 | (32'd3 << 23));
    n0 = frames; waitFrame(n0); waitFrame(n0 + 1);
    chk("R8 rate 10Hz", storeCyc - prevStoreCyc, CLK_HZ / 10);
    wr(5'h04, 32'h8000_0001 | (32'd2 << 23));
    n0 = frames; waitFrame(n0); waitFrame(n0 + 1); waitFrame(n0 + 2);
    chk("R8 rate 8Hz", storeCyc - prevStoreCyc, CLK_HZ / 8);
    // R9 software request in the same cycle as a tick
    t = storeCyc + CLK_HZ / 8 - 1 - 16;
    while (cyc < t - 2) @(posedge clk);
    n0 = frames;
    wr(5'h00, 32'h8000_0000);
    waitFrame(n0);
    chk("R9 coincident start", storeCyc, t + 17);
    rd(5'h00, r); chk("R9 coincident cleared", r[31], 0);
    repeat (200) @(negedge clk);
    chk("R9 single frame", frames, n0 + 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule